// File: doc/BRIEF.md
# Serial 101 Detector with Mealy and Moore Outputs

This block watches a one-bit serial stream and flags every occurrence of the pattern 101. A bit is taken only in clock cycles where the strobe `bit_valid` is high. Cycles without the strobe leave the machine where it was.

Each detection is reported twice. `hit_mealy` is decoded from the current state and the incoming bit, so it is high in the same cycle as the completing 1. `hit_moore` is decoded from a registered accept state, so it appears one cycle later and stays high for as long as the machine rests there. A mode input picks where the machine goes after a match. With overlapping matching, the completing 1 is kept as the start of the next pattern. With non-overlapping matching, the machine drops back to idle. An 8-bit counter tallies the matches and stops at its maximum.

Top module: `serial_101_detector`

## Requirements
- R1: While `rst` is high at a clock edge, the machine is forced to idle and the match count to 0. After that edge `hit_moore` is 0, and `hit_mealy` is 0 until a complete 101 arrives.
- R2: `hit_mealy` is 1 in exactly the cycle where `bit_valid` is 1, `bit_in` is 1 and the two earlier accepted bits were 1 then 0.
- R3: `hit_moore` goes to 1 in the cycle after each `hit_mealy` pulse. It stays 1 while no further bit is accepted and drops after the next accepted bit.
- R4: With `overlap_en`=1 the completing 1 counts as the start of a new pattern, so the accepted stream 10101 gives 2 matches, on bits 3 and 5.
- R5: With `overlap_en`=0 a match returns the machine to idle, so 10101 gives 1 match, on bit 3.
- R6: A run of 1s keeps the machine in its "seen 1" state, so 1101 gives a match on bit 4.
- R7: A stream of only 0s, or no accepted bits at all, never raises either output.
- R8: While `bit_valid` is 0 the state holds, `hit_mealy` is 0 and the count does not change.
- R9: `match_count` rises by 1 for each `hit_mealy` pulse and saturates at 255 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | High when `bit_in` carries a bit to take |
| bit_in | input | 1 | Serial data bit |
| overlap_en | input | 1 | 1 = overlapping matching, 0 = non-overlapping matching |
| hit_mealy | output | 1 | Match flag in the same cycle as the completing bit |
| hit_moore | output | 1 | Match flag shown while the machine is in the accept state |
| match_count | output | 8 | Saturating count of matches |

## Verification
The stream 10101 is sent in both modes. The difference between 2 matches and 1 match separates overlapping from non-overlapping return after a match. The stream 1101 checks that repeated 1s do not lose the prefix. An all-zero stream and a run of cycles without the strobe check that nothing is invented. Gaps in the strobe placed inside a pattern and right after a match show that the state holds and that `hit_moore` lingers while `hit_mealy` stays low. A long run of 01 pairs drives the counter past 255.

// File: rtl/det_pkg.sv
package det_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ONE  = 3'd1,
    ST_ONEZ = 3'd2,
    ST_ACC  = 3'd3
  } det_state_t;
endpackage

// File: rtl/det_fsm.sv
module det_fsm
  import det_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_valid,
  input  logic       bit_in,
  input  logic       overlap_en,
  output det_state_t state_q,
  output logic       match_now
);
  det_state_t state_d;

  // Total next-state table; any code outside the four legal ones goes to idle.
  always_comb begin
    state_d = state_q;
    if (bit_valid) begin
      unique case (state_q)
        ST_IDLE: state_d = bit_in ? ST_ONE : ST_IDLE;
        ST_ONE:  state_d = bit_in ? ST_ONE : ST_ONEZ;
        ST_ONEZ: state_d = bit_in ? ST_ACC : ST_IDLE;
        ST_ACC: begin
          if (bit_in)          state_d = ST_ONE;
          else if (overlap_en) state_d = ST_ONEZ;
          else                 state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign match_now = bit_valid && bit_in && (state_q == ST_ONEZ);

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // R8: no strobe, no movement
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(state_q));
  // R5: non-overlapping mode never resumes at "seen 10" after accept
  p_nonoverlap_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACC && bit_valid && !overlap_en) |=> (state_q != ST_ONEZ));
  // R4: overlapping mode keeps the completing 1 as a prefix
  p_overlap_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACC && bit_valid && overlap_en && !bit_in) |=> (state_q == ST_ONEZ));
  // R7: a 0 in idle never leaves idle
  p_zero_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && bit_valid && !bit_in) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/det_sat_counter.sv
module det_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                          count_q <= '0;
    else if (inc && count_q != CNT_MAX) count_q <= count_q + 1'b1;
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (count_q == CNT_MAX) |=> (count_q == CNT_MAX));
  p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    (inc && count_q != CNT_MAX) |=> (count_q == $past(count_q) + 1'b1));
  p_count_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(count_q));
endmodule

// File: rtl/serial_101_detector.sv
module serial_101_detector
  import det_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             overlap_en,
  output logic             hit_mealy,
  output logic             hit_moore,
  output logic [CNT_W-1:0] match_count
);
  det_state_t state_q;
  logic       match_now;

  det_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .bit_valid  (bit_valid),
    .bit_in     (bit_in),
    .overlap_en (overlap_en),
    .state_q    (state_q),
    .match_now  (match_now)
  );

  det_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .inc     (match_now),
    .count_q (match_count)
  );

  assign hit_mealy = match_now;
  assign hit_moore = (state_q == ST_ACC);

  // R3: Moore follows Mealy by one cycle
  p_moore_follows_r3: assert property (@(posedge clk) disable iff (rst)
    hit_mealy |=> hit_moore);
  p_moore_source_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(hit_moore) |-> $past(hit_mealy));
  // R8: no Mealy flag without a strobe
  p_mealy_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |-> !hit_mealy);
endmodule

// File: tb/serial_101_detector_tb.sv
module serial_101_detector_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic       overlap_en = 1'b1;
  logic       hit_mealy, hit_moore;
  logic [7:0] match_count;
  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  serial_101_detector u_dut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .overlap_en(overlap_en), .hit_mealy(hit_mealy), .hit_moore(hit_moore),
    .match_count(match_count)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_valid = 1'b0; bit_in = 1'b0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  // Drive one cycle; check Mealy before the edge and Moore after it.
  task automatic step(input logic v, input logic b, input int em, input int eo, input string req);
    @(negedge clk);
    bit_valid = v; bit_in = b;
    #1 check({req, " mealy"}, int'(hit_mealy), em);
    @(posedge clk); #1;
    check({req, " moore"}, int'(hit_moore), eo);
  endtask

  task automatic t_reset_r1();
    do_reset();
    #1;
    check("R1 count", int'(match_count), 0);
    check("R1 moore", int'(hit_moore), 0);
    check("R1 mealy", int'(hit_mealy), 0);
  endtask

  task automatic t_overlap_r4();
    overlap_en = 1'b1; do_reset();
    step(1, 1, 0, 0, "R4");
    step(1, 0, 0, 0, "R4");
    step(1, 1, 1, 1, "R4 R2");
    step(1, 0, 0, 0, "R4 R3");
    step(1, 1, 1, 1, "R4 R2");
    check("R4 count", int'(match_count), 2);
  endtask

  task automatic t_nonoverlap_r5();
    overlap_en = 1'b0; do_reset();
    step(1, 1, 0, 0, "R5");
    step(1, 0, 0, 0, "R5");
    step(1, 1, 1, 1, "R5");
    step(1, 0, 0, 0, "R5");
    step(1, 1, 0, 0, "R5");
    check("R5 count", int'(match_count), 1);
    overlap_en = 1'b1;
  endtask

  task automatic t_ones_r6();
    do_reset();
    step(1, 1, 0, 0, "R6");
    step(1, 1, 0, 0, "R6");
    step(1, 0, 0, 0, "R6");
    step(1, 1, 1, 1, "R6");
    check("R6 count", int'(match_count), 1);
  endtask

  task automatic t_zeros_r7();
    do_reset();
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, "R7 zeros");
    for (int i = 0; i < 6; i++) step(0, 1, 0, 0, "R7 no strobe");
    check("R7 count", int'(match_count), 0);
  endtask

  task automatic t_gap_r8();
    do_reset();
    step(1, 1, 0, 0, "R8");
    step(1, 0, 0, 0, "R8");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R8 gap");
    check("R8 count gap", int'(match_count), 0);
    step(1, 1, 1, 1, "R8 resume");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, "R8 R3 linger");
    check("R8 count held", int'(match_count), 1);
    step(1, 1, 0, 0, "R3 drop");
  endtask

  task automatic t_reset_mid_r1();
    do_reset();
    step(1, 1, 0, 0, "R1 mid");
    step(1, 0, 0, 0, "R1 mid");
    do_reset();
    step(1, 1, 0, 0, "R1 after reset");
    check("R1 count mid", int'(match_count), 0);
  endtask

  task automatic t_saturate_r9();
    overlap_en = 1'b1; do_reset();
    step(1, 1, 0, 0, "R9");
    for (int i = 0; i < 254; i++) begin
      step(1, 0, 0, 0, "R9");
      step(1, 1, 1, 1, "R9");
    end
    check("R9 count 254", int'(match_count), 254);
    for (int i = 0; i < 20; i++) begin
      step(1, 0, 0, 0, "R9");
      step(1, 1, 1, 1, "R9");
    end
    check("R9 saturated", int'(match_count), 255);
  endtask

  initial begin
    t_reset_r1();
    t_overlap_r4();
    t_nonoverlap_r5();
    t_ones_r6();
    t_zeros_r7();
    t_gap_r8();
    t_reset_mid_r1();
    t_saturate_r9();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule